// File: doc/BRIEF.md
# Banked Register Access Sequencer

This block lets a host that thinks in flat register addresses reach a peripheral whose 16-bit registers are spread over several banks. Only eight word slots are visible at a time. One of them, the selector slot, chooses which bank the other seven slots map to. The host issues one request with a valid/ready handshake. For a banked request the block first reads the selector to remember the bank that was active. It then writes the target bank into the selector, performs the requested read or write, and finally writes the remembered bank back. It raises a one-cycle done pulse at the end.

While a banked sequence runs, the host-side ready stays low. No other request can start or interleave, so the save, select, access and restore steps form one indivisible operation. A fast request skips all bank handling. It performs a single access to the slot named by the address within whatever bank is currently selected.

The peripheral side is a simple strobe bus. Each strobe lasts one cycle and carries a word address, a write enable and write data. Read data is returned one cycle after a read strobe.

Top module: `banked_access_seq`

## Requirements
- R1: The 7-bit request address splits into a bank number in bits [6:4] and a byte offset in bits [3:0]. The word slot driven on the peripheral bus is address bits [3:1], and address bit 0 has no effect.
- R2: A banked request produces exactly four strobes on consecutive cycles, in this order: a read of slot 7, a write of the zero-extended target bank to slot 7, the requested access to the target slot, and a write to slot 7.
- R3: The final write of a banked request carries only the low three bits of the value read from slot 7 at its start, zero-extended to 16 bits. The selector therefore ends up holding the bank that was active before the request.
- R4: A banked read returns on rsp_rdata the word the target slot held in the target bank. A banked read of slot 7 returns the target bank number, because the select write happens before the access.
- R5: A fast request produces exactly one strobe, to slot bits [3:1] of the current bank, and never touches the selector unless it targets slot 7 itself. A fast read returns that slot's word, and address bits [6:4] have no effect.
- R6: req_ready is low from the cycle after a request is accepted until the sequence's last strobe has been issued. No strobe is issued while req_ready is high, and a request held during a sequence starts only after the restore write.
- R7: rsp_done is a single-cycle pulse that occurs once per request, and rsp_rdata is valid while it is high.
- R8: During reset no strobe is issued and rsp_done and req_ready are low. req_ready rises within three cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fast | input | 1 | 1 = fast access without bank handling |
| req_addr | input | 7 | Flat register address (bank, byte offset) |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| per_stb | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | 3 | Peripheral word slot |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, one cycle after a read strobe |

## Verification
The bench builds the block with its default parameters: eight banks of eight 16-bit slots, with the selector in slot 7. At that size every one of the 128 flat addresses can be exercised from each of the eight starting banks. The selector is preloaded with upper bits set, so the masking in the restore write shows up at the ports. Each request's strobe trace is compared step by step against the required order. A held-over request during a banked sequence confirms that nothing interleaves with it.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_SEL   = 3'd2,
    ST_ACC   = 3'd3,
    ST_RST   = 3'd4,
    ST_FAST  = 3'd5,
    ST_FWAIT = 3'd6
  } bas_state_e;

endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bas_decode.sv
module bas_decode #(
  parameter int BANK_W = 3,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = BANK_W + SLOT_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [SLOT_W-1:0] slot
);

  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign slot = addr[SLOT_W:1];

endmodule

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       req_valid,
  input  logic       req_fast,
  input  logic       op_wr_q,
  output bas_state_e state_q,
  output logic       req_ready,
  output logic       accept
);

  bas_state_e state_d;

  assign req_ready = run && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = req_fast ? ST_FAST : ST_SAVE;
      ST_SAVE:  state_d = ST_SEL;
      ST_SEL:   state_d = ST_ACC;
      ST_ACC:   state_d = ST_RST;
      ST_RST:   state_d = ST_IDLE;
      ST_FAST:  state_d = op_wr_q ? ST_IDLE : ST_FWAIT;
      ST_FWAIT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/bas_datapath.sv
module bas_datapath
  import bas_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 3,
  parameter int SLOT_W   = 3,
  parameter int SEL_SLOT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bas_state_e        state_q,
  input  logic              accept,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BANK_W-1:0] dec_bank,
  input  logic [SLOT_W-1:0] dec_slot,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              op_wr_q,
  output logic              per_stb,
  output logic              per_we,
  output logic [SLOT_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int PAD_W = DATA_W - BANK_W;
  localparam logic [SLOT_W-1:0] SEL_ADDR = SEL_SLOT[SLOT_W-1:0];

  logic [BANK_W-1:0] bank_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BANK_W-1:0] saved_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  logic              lat_en;
  logic              sav_en;
  logic              rd_en;
  logic              done_d;

  assign lat_en = accept;
  assign sav_en = (state_q == ST_SEL);
  assign rd_en  = ((state_q == ST_RST) && !op_wr_q) || (state_q == ST_FWAIT);
  assign done_d = (state_q == ST_RST) || (state_q == ST_FWAIT) ||
                  ((state_q == ST_FAST) && op_wr_q);

  always_comb begin
    per_stb   = 1'b0;
    per_we    = 1'b0;
    per_addr  = '0;
    per_wdata = '0;
    case (state_q)
      ST_SAVE: begin
        per_stb  = 1'b1;
        per_addr = SEL_ADDR;
      end
      ST_SEL: begin
        per_stb   = 1'b1;
        per_we    = 1'b1;
        per_addr  = SEL_ADDR;
        per_wdata = {{PAD_W{1'b0}}, bank_q};
      end
      ST_ACC, ST_FAST: begin
        per_stb   = 1'b1;
        per_we    = op_wr_q;
        per_addr  = slot_q;
        per_wdata = op_wr_q ? wdata_q : '0;
      end
      ST_RST: begin
        per_stb   = 1'b1;
        per_we    = 1'b1;
        per_addr  = SEL_ADDR;
        per_wdata = {{PAD_W{1'b0}}, saved_q};
      end
      default: begin
        per_stb = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      bank_q  <= '0;
      slot_q  <= '0;
      wdata_q <= '0;
      saved_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (lat_en) begin
        op_wr_q <= req_write;
        bank_q  <= dec_bank;
        slot_q  <= dec_slot;
        wdata_q <= req_wdata;
      end
      if (sav_en) begin
        saved_q <= per_rdata[BANK_W-1:0];
      end
      if (rd_en) begin
        rdata_q <= per_rdata;
      end
      done_q <= done_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/banked_access_seq.sv
module banked_access_seq
  import bas_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 3,
  parameter int SLOT_W   = 3,
  parameter int SEL_SLOT = 7,
  parameter int ADDR_W   = BANK_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fast,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              per_stb,
  output logic              per_we,
  output logic [SLOT_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);

  logic              rst_n_int;
  logic              accept;
  logic              op_wr_q;
  bas_state_e        state_q;
  logic [BANK_W-1:0] dec_bank;
  logic [SLOT_W-1:0] dec_slot;

  bas_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bas_decode #(.BANK_W(BANK_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .bank (dec_bank),
    .slot (dec_slot)
  );

  bas_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run       (rst_n_int),
    .req_valid (req_valid),
    .req_fast  (req_fast),
    .op_wr_q   (op_wr_q),
    .state_q   (state_q),
    .req_ready (req_ready),
    .accept    (accept)
  );

  bas_datapath #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W), .SEL_SLOT(SEL_SLOT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .state_q   (state_q),
    .accept    (accept),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .dec_bank  (dec_bank),
    .dec_slot  (dec_slot),
    .per_rdata (per_rdata),
    .op_wr_q   (op_wr_q),
    .per_stb   (per_stb),
    .per_we    (per_we),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 3,
  parameter int SLOT_W   = 3,
  parameter int SEL_SLOT = 7,
  parameter int ADDR_W   = BANK_W + SLOT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_fast,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_done,
  input logic              per_stb,
  input logic              per_we,
  input logic [SLOT_W-1:0] per_addr,
  input logic [DATA_W-1:0] per_wdata,
  input logic [DATA_W-1:0] per_rdata
);

  localparam int PAD_W = DATA_W - BANK_W;
  localparam logic [SLOT_W-1:0] SEL_ADDR = SEL_SLOT[SLOT_W-1:0];

  logic              acc;
  logic [2:0]        ph_q;
  logic              fast_q;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] sav_q;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 3'd4;
      fast_q <= 1'b1;
      bank_q <= '0;
      sav_q  <= '0;
    end else begin
      if (acc) begin
        ph_q   <= 3'd0;
        fast_q <= req_fast;
        bank_q <= req_addr[ADDR_W-1 -: BANK_W];
      end else if (per_stb && ph_q != 3'd4) begin
        ph_q <= ph_q + 3'd1;
      end
      if (!fast_q && ph_q == 3'd1) begin
        sav_q <= per_rdata[BANK_W-1:0];
      end
    end
  end

  AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_fast |=> per_stb && !per_we && per_addr == SEL_ADDR); // R2

  AST_SELECT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb && !fast_q && ph_q == 3'd1 |-> per_we && per_addr == SEL_ADDR &&
    per_wdata == {{PAD_W{1'b0}}, bank_q}); // R2

  AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb && !fast_q && ph_q == 3'd3 |-> per_we && per_addr == SEL_ADDR &&
    per_wdata == {{PAD_W{1'b0}}, sav_q}); // R3

  AST_FOUR_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !fast_q |-> ph_q == 3'd4); // R2

  AST_FAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_fast |=> per_stb && per_addr == $past(req_addr[SLOT_W:1])); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !per_stb); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7

endmodule

bind banked_access_seq bas_chk #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W),
  .SEL_SLOT(SEL_SLOT), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_fast  (req_fast),
  .req_addr  (req_addr),
  .rsp_done  (rsp_done),
  .per_stb   (per_stb),
  .per_we    (per_we),
  .per_addr  (per_addr),
  .per_wdata (per_wdata),
  .per_rdata (per_rdata)
);

// File: tb/banked_access_seq_tb_top.sv
module banked_access_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic        req_fast;
  logic [6:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        per_stb;
  logic        per_we;
  logic [2:0]  per_addr;
  logic [15:0] per_wdata;
  logic [15:0] per_rdata;

  int checks;
  int errors;
  bit finished;

  logic [15:0] pmem [0:63];
  logic [15:0] psel;
  logic [15:0] shadow [0:63];

  int          log_n;
  logic        log_we [0:15];
  logic [2:0]  log_a  [0:15];
  logic [15:0] log_d  [0:15];

  banked_access_seq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_fast  (req_fast),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .per_stb   (per_stb),
    .per_we    (per_we),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .per_rdata (per_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // peripheral model: slot 7 is the selector, others are banked words
  always @(posedge clk) begin
    if (per_stb) begin
      if (per_we) begin
        if (per_addr == 3'd7) psel <= per_wdata;
        else pmem[{psel[2:0], per_addr}] <= per_wdata;
      end else begin
        per_rdata <= (per_addr == 3'd7) ? psel : pmem[{psel[2:0], per_addr}];
      end
    end
  end

  // strobe trace
  initial log_n = 0;
  always @(posedge clk) begin
    if (per_stb) begin
      log_we[log_n % 16] <= per_we;
      log_a[log_n % 16]  <= per_addr;
      log_d[log_n % 16]  <= per_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit fast, input bit wr, input logic [6:0] addr,
                    input logic [15:0] wd, output logic [15:0] rd, output int base);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base      = log_n;
    req_valid = 1'b1;
    req_fast  = fast;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R7 done pulse", {31'd0, rsp_done}, 32'd0);
  endtask

  function automatic logic [15:0] pat(input int a, input int sb);
    return 16'((a * 16'h0123) ^ (sb << 12) ^ 16'h5A3C);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int          base;
    checks    = 0;
    errors    = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_fast  = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!per_stb, "R8 no strobe in reset", {31'd0, per_stb}, 32'd0);
    chk(!rsp_done, "R8 no done in reset", {31'd0, rsp_done}, 32'd0);
    chk(!req_ready, "R8 not ready in reset", {31'd0, req_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R8 ready after release", {31'd0, req_ready}, 32'd1);

    // banked writes (and slot-7 reads) over all addresses from every start bank
    for (int sb = 0; sb < 8; sb++) begin
      for (int a = 0; a < 128; a++) begin
        logic [2:0]  bk;
        logic [2:0]  sl;
        logic [15:0] d;
        bk = 3'(a >> 4);
        sl = 3'(a >> 1);
        op(1'b1, 1'b1, 7'h0E, 16'hA5F8 | 16'(sb), rd, base);
        if (sl != 3'd7) begin
          d = pat(a, sb);
          op(1'b0, 1'b1, 7'(a), d, rd, base);
          shadow[{bk, sl}] = d;
          chk(log_a[(base + 2) % 16] == sl && log_we[(base + 2) % 16] &&
              log_d[(base + 2) % 16] == d, "R1 target slot write",
              {13'd0, log_a[(base + 2) % 16], log_d[(base + 2) % 16]}, {13'd0, sl, d});
        end else begin
          op(1'b0, 1'b0, 7'(a), 16'h0, rd, base);
          chk(rd == {13'd0, bk}, "R4 slot7 banked read", rd, {29'd0, bk});
        end
        chk(log_n - base == 4, "R2 strobe count", log_n - base, 4);
        chk(!log_we[base % 16] && log_a[base % 16] == 3'd7, "R2 save read",
            {log_we[base % 16], log_a[base % 16]}, {1'b0, 3'd7});
        chk(log_we[(base + 1) % 16] && log_a[(base + 1) % 16] == 3'd7 &&
            log_d[(base + 1) % 16] == {13'd0, bk}, "R2 select write",
            log_d[(base + 1) % 16], {29'd0, bk});
        chk(log_we[(base + 3) % 16] && log_a[(base + 3) % 16] == 3'd7 &&
            log_d[(base + 3) % 16] == 16'(sb), "R3 restore write",
            log_d[(base + 3) % 16], sb);
        op(1'b1, 1'b0, 7'h0E, 16'h0, rd, base);
        chk(rd == 16'(sb), "R3 selector after banked op", rd, sb);
      end
    end

    // banked reads of every data slot, including odd byte offsets
    for (int sb = 0; sb < 8; sb++) begin
      for (int a = 0; a < 128; a++) begin
        logic [2:0] bk;
        logic [2:0] sl;
        bk = 3'(a >> 4);
        sl = 3'(a >> 1);
        if (sl != 3'd7) begin
          op(1'b1, 1'b1, 7'h0E, 16'(sb), rd, base);
          op(1'b0, 1'b0, 7'(a), 16'h0, rd, base);
          chk(rd == shadow[{bk, sl}], "R4 banked read data", rd, shadow[{bk, sl}]);
          chk(!log_we[(base + 2) % 16] && log_a[(base + 2) % 16] == sl,
              "R2 target read slot", log_a[(base + 2) % 16], sl);
        end
      end
    end

    // fast path: current bank only, bank bits ignored, selector untouched
    for (int b = 0; b < 8; b++) begin
      op(1'b1, 1'b1, 7'h7E, 16'(b), rd, base);
      for (int s = 0; s < 7; s++) begin
        logic [6:0]  fa;
        logic [15:0] nd;
        fa = {~3'(b), 3'(s), 1'b1};
        op(1'b1, 1'b0, fa, 16'h0, rd, base);
        chk(rd == shadow[{3'(b), 3'(s)}], "R5 fast read data", rd, shadow[{3'(b), 3'(s)}]);
        chk(log_n - base == 1 && log_a[base % 16] == 3'(s), "R5 single strobe",
            log_n - base, 1);
        nd = ~pat(s, b);
        op(1'b1, 1'b1, fa, nd, rd, base);
        shadow[{3'(b), 3'(s)}] = nd;
        chk(log_n - base == 1 && log_we[base % 16] && log_a[base % 16] == 3'(s),
            "R5 fast write strobe", log_n - base, 1);
        op(1'b1, 1'b0, {3'(b), 3'(s), 1'b0}, 16'h0, rd, base);
        chk(rd == nd, "R5 fast readback", rd, nd);
      end
      op(1'b1, 1'b0, 7'h0E, 16'h0, rd, base);
      chk(rd == 16'(b), "R5 selector unchanged", rd, b);
    end

    // hold-off: second request held during a banked sequence
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    op(1'b1, 1'b1, 7'h0E, 16'h0005, rd, base);
    @(negedge clk);
    base      = log_n;
    req_valid = 1'b1;
    req_fast  = 1'b0;
    req_write = 1'b1;
    req_addr  = 7'h12;
    req_wdata = 16'hBEEF;
    @(negedge clk);
    req_addr  = 7'h34;
    req_wdata = 16'hCAFE;
    chk(!req_ready, "R6 busy after accept", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready, "R6 busy during sequence", {31'd0, req_ready}, 32'd0);
    end
    @(negedge clk);
    chk(req_ready && rsp_done, "R7 done with ready", {30'd0, req_ready, rsp_done}, 32'd3);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
    chk(log_n - base == 8, "R6 no interleave count", log_n - base, 8);
    chk(!log_we[(base + 4) % 16] && log_a[(base + 4) % 16] == 3'd7,
        "R6 second starts with save", log_a[(base + 4) % 16], 7);
    chk(log_d[(base + 3) % 16] == 16'h0005 && log_d[(base + 7) % 16] == 16'h0005,
        "R3 both restores", log_d[(base + 7) % 16], 16'h0005);
    op(1'b1, 1'b1, 7'h0E, 16'h0001, rd, base);
    op(1'b1, 1'b0, 7'h02, 16'h0, rd, base);
    chk(rd == 16'hBEEF, "R6 first request landed", rd, 16'hBEEF);
    op(1'b1, 1'b1, 7'h0E, 16'h0003, rd, base);
    op(1'b1, 1'b0, 7'h04, 16'h0, rd, base);
    chk(rd == 16'hCAFE, "R6 second request landed", rd, 16'hCAFE);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule